// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block turns a CPU physical address and a byte-lane request into the pin sequence for an asynchronous DRAM with two banks. It drives a row address on a 13-pin shared address bus and strobes the row line of the selected bank. It then drives the column address and pulls low one column strobe for each byte lane the access touches. A configuration input selects a 16-bit or a 32-bit data bus. Both banks always share that width.

Row and column bits interleave the upper address bits, so any square device from 4 Mbit to 1 Gbit works without configuration. A smaller device aliases within its 256-Mbyte bank. The mapping moves up one bit in 32-bit mode. A request may ask for a sequential burst of up to eight beats. The block generates the address of each beat itself. When the next beat leaves the smallest page, the block precharges and opens the new row. The CPU side uses a request/acknowledge handshake: the requester holds `req_i` until `ack_o` pulses.

Top module: `dram_addr_mux`

## Requirements
- R1: Column pins 0..7 carry address bits 1..8 and pins 8..12 carry bits 18,20,22,24,26 when `cfg_wide_i`=0. When `cfg_wide_i`=1 every source bit is one higher (2..9; 19,21,23,25,27).
- R2: Row pins 0..8 carry address bits 9..17 and pins 9..12 carry bits 19,21,23,25 when `cfg_wide_i`=0. When `cfg_wide_i`=1 they carry 10..18 and 20,22,24,26.
- R3: Address bit 28 selects the bank. Bank 0 pulls `ras_n_o[0]` low and bank 1 pulls `ras_n_o[1]` low.
- R4: A request whose address bits 31..29 are not all zero is never acknowledged and drives no row strobe.
- R5: In 32-bit mode the lane mask is applied to `cas_n_o` (active low, bit n = byte lane n). A word (size 2) enables lanes 3..0. A halfword (size 1) enables lanes 1..0 or 3..2 by address bit 1. A byte (size 0) enables lane = address bits 1..0.
- R6: In 16-bit mode only `cas_n_o[1:0]` are used. A byte enables lane = address bit 0, and any wider size enables lanes 1..0.
- R7: Before the row strobe falls, the row address is on the bus for one setup cycle. The strobe stays low for `cfg_trcd_i` cycles before the column strobes fall. Column strobes stay low for `cfg_tcas_i` cycles, and column strobes are only low while a row strobe is low.
- R8: After the last beat, or before a new row opens, all row strobes are high for `cfg_trp_i`+1 cycles. This counts the precharge plus the setup or acknowledge cycle.
- R9: A burst of `req_len_i`+1 beats advances the address by 2 (16-bit) or 4 (32-bit) bytes per beat, and the block generates the low column bits itself. Beats inside one page share a single row strobe, and the column address is stable while the column strobes are low.
- R10: When the next beat crosses a page boundary, the row strobe rises and the new row is opened. The boundary is address bit 9 in 16-bit mode and bit 10 in 32-bit mode.
- R11: `ack_o` is a single-cycle pulse, given once per accepted request after the final precharge.
- R12: At most one row strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wide_i | input | 1 | 1 = 32-bit memory bus, 0 = 16-bit |
| cfg_trcd_i | input | 4 | Row-to-column delay in cycles (0 treated as 1) |
| cfg_tcas_i | input | 4 | Column strobe pulse width in cycles (0 treated as 1) |
| cfg_trp_i | input | 4 | Precharge cycles (0 treated as 1) |
| req_i | input | 1 | Access request, held until ack |
| req_addr_i | input | 32 | Physical byte address of first beat |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_len_i | input | 3 | Beats minus one |
| ack_o | output | 1 | Completion pulse |
| ras_n_o | output | 2 | Row strobes, one per bank, active low |
| cas_n_o | output | 4 | Column strobes, one per byte lane, active low |
| dram_a_o | output | 13 | Multiplexed row/column address |

## Verification
The bench compares every row and column word against its own mapping in both width modes, for fixed and random addresses. A one-bit slip in either mapping shows up as a mismatched pin. Bursts that start just below a page boundary in each mode check the precharge and reopen. A design that keeps the old row would show one row strobe too few, and one that misses the boundary width would reopen at the wrong beat. Halfword and byte accesses on every lane check the strobe decoder, which would otherwise enable the wrong lane or the upper strobes in 16-bit mode. An address above both banks checks that the request is ignored: no strobe falls and no acknowledge arrives.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  localparam int ADDR_W  = 32;
  localparam int PIN_W   = 13;
  localparam int LANE_W  = 4;
  localparam int BANK_W  = 2;
  localparam int BANK_BIT = 28;
  localparam int COL_LIN = 8;   // contiguous low column pins
  localparam int ROW_LIN = 9;   // contiguous low row pins
  localparam int PAGE_LSB = 9;  // 16-bit page boundary bit

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_RCD, ST_CAS, ST_CPRE, ST_PRE, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/dram_addr_map.sv
module dram_addr_map
  import dram_mux_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PIN_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wide_i,
  output logic [PW-1:0] row_o,
  output logic [PW-1:0] col_o
);
  logic [PW-1:0] row_n, row_w, col_n, col_w;

  for (genvar i = 0; i < PW; i++) begin : g_pin
    if (i < COL_LIN) begin : g_col_lin
      assign col_n[i] = addr_i[i+1];
      assign col_w[i] = addr_i[i+2];
    end else begin : g_col_ilv
      assign col_n[i] = addr_i[18+2*(i-COL_LIN)];
      assign col_w[i] = addr_i[19+2*(i-COL_LIN)];
    end
    if (i < ROW_LIN) begin : g_row_lin
      assign row_n[i] = addr_i[9+i];
      assign row_w[i] = addr_i[10+i];
    end else begin : g_row_ilv
      assign row_n[i] = addr_i[19+2*(i-ROW_LIN)];
      assign row_w[i] = addr_i[20+2*(i-ROW_LIN)];
    end
  end

  assign row_o = wide_i ? row_w : row_n;
  assign col_o = wide_i ? col_w : col_n;
endmodule

// File: rtl/dram_lane_dec.sv
module dram_lane_dec
  import dram_mux_pkg::*;
#(
  parameter int LW = LANE_W
) (
  input  logic          wide_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    low_i,
  output logic [LW-1:0] lanes_o
);
  always_comb begin
    lanes_o = '0;
    if (wide_i) begin
      unique case (size_i)
        SZ_BYTE: lanes_o[low_i] = 1'b1;
        SZ_HALF: begin
          lanes_o[{low_i[1], 1'b0}] = 1'b1;
          lanes_o[{low_i[1], 1'b1}] = 1'b1;
        end
        default: lanes_o = '1;
      endcase
    end else begin
      if (size_i == SZ_BYTE) lanes_o[{1'b0, low_i[0]}] = 1'b1;
      else                   lanes_o[1:0] = 2'b11;
    end
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_mux_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int CNT_W = 4,
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] trcd_i,
  input  logic [CNT_W-1:0] tcas_i,
  input  logic [CNT_W-1:0] trp_i,
  input  logic             req_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [1:0]       req_size_i,
  input  logic [LEN_W-1:0] req_len_i,
  output seq_state_e       state_o,
  output logic [AW-1:0]    addr_o,
  output logic [1:0]       size_o
);
  localparam int TOP_LSB = BANK_BIT + 1;

  seq_state_e       state_q;
  logic [AW-1:0]    addr_q, addr_nx;
  logic [1:0]       size_q;
  logic [LEN_W-1:0] left_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_q;
  logic             in_range, page_cross;
  int unsigned      page_sh;

  function automatic logic [CNT_W-1:0] ld(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign in_range   = (req_addr_i[AW-1:TOP_LSB] == '0);
  assign addr_nx    = addr_q + (wide_i ? AW'(4) : AW'(2));
  assign page_sh    = PAGE_LSB + 32'(wide_i);
  assign page_cross = (addr_nx >> page_sh) != (addr_q >> page_sh);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      left_q  <= '0;
      cnt_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i && in_range) begin
          addr_q  <= req_addr_i;
          size_q  <= req_size_i;
          left_q  <= req_len_i;
          last_q  <= 1'b0;
          state_q <= ST_ROW;
        end
        ST_ROW: begin
          cnt_q   <= ld(trcd_i);
          state_q <= ST_RCD;
        end
        ST_RCD: begin
          if (cnt_q == '0) begin
            cnt_q   <= ld(tcas_i);
            state_q <= ST_CAS;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_CAS: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (left_q == '0) begin
            last_q  <= 1'b1;
            cnt_q   <= ld(trp_i);
            state_q <= ST_PRE;
          end else begin
            addr_q <= addr_nx;
            left_q <= left_q - 1'b1;
            if (page_cross) begin
              cnt_q   <= ld(trp_i);
              state_q <= ST_PRE;
            end else state_q <= ST_CPRE;
          end
        end
        ST_CPRE: begin
          cnt_q   <= ld(tcas_i);
          state_q <= ST_CAS;
        end
        ST_PRE: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else state_q <= last_q ? ST_DONE : ST_ROW;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign addr_o  = addr_q;
  assign size_o  = size_q;
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_mux_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LEN_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wide_i,
  input  logic [CNT_W-1:0]   cfg_trcd_i,
  input  logic [CNT_W-1:0]   cfg_tcas_i,
  input  logic [CNT_W-1:0]   cfg_trp_i,
  input  logic               req_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic [LEN_W-1:0]   req_len_i,
  output logic               ack_o,
  output logic [BANK_W-1:0]  ras_n_o,
  output logic [LANE_W-1:0]  cas_n_o,
  output logic [PIN_W-1:0]   dram_a_o
);
  seq_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        cur_size;
  logic [PIN_W-1:0]  row_a, col_a;
  logic [LANE_W-1:0] lanes;
  logic              row_open, col_phase;

  dram_seq #(.AW(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) seq_i (
    .clk_i, .rst_ni,
    .wide_i     (cfg_wide_i),
    .trcd_i     (cfg_trcd_i),
    .tcas_i     (cfg_tcas_i),
    .trp_i      (cfg_trp_i),
    .req_i, .req_addr_i, .req_size_i, .req_len_i,
    .state_o    (state),
    .addr_o     (cur_addr),
    .size_o     (cur_size)
  );

  dram_addr_map #(.AW(ADDR_W), .PW(PIN_W)) map_i (
    .addr_i (cur_addr),
    .wide_i (cfg_wide_i),
    .row_o  (row_a),
    .col_o  (col_a)
  );

  dram_lane_dec #(.LW(LANE_W)) lane_i (
    .wide_i  (cfg_wide_i),
    .size_i  (cur_size),
    .low_i   (cur_addr[1:0]),
    .lanes_o (lanes)
  );

  assign row_open  = (state == ST_RCD) || (state == ST_CAS) || (state == ST_CPRE);
  assign col_phase = (state == ST_CAS) || (state == ST_CPRE);

  always_comb begin
    ras_n_o = '1;
    if (row_open) ras_n_o[cur_addr[BANK_BIT]] = 1'b0;
  end

  assign cas_n_o  = (state == ST_CAS) ? ~lanes : '1;
  assign dram_a_o = col_phase ? col_a : row_a;
  assign ack_o    = (state == ST_DONE);
endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_wide_i,
  input logic [3:0]  cfg_trcd_i,
  input logic [3:0]  cfg_tcas_i,
  input logic [3:0]  cfg_trp_i,
  input logic        req_i,
  input logic [31:0] req_addr_i,
  input logic [1:0]  req_size_i,
  input logic [2:0]  req_len_i,
  input logic        ack_o,
  input logic [1:0]  ras_n_o,
  input logic [3:0]  cas_n_o,
  input logic [12:0] dram_a_o
);
  logic cas_act;
  assign cas_act = (cas_n_o != 4'hF);

  // R12
  one_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ras_n_o) <= 1);

  // R7
  cas_in_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_act |-> (ras_n_o != 2'b11));

  // R6
  narrow_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wide_i |-> (cas_n_o[3:2] == 2'b11));

  // R11
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R9
  col_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_act && $past(cas_act)) |-> $stable(dram_a_o));

  // R8
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (ras_n_o == 2'b11 && !cas_act));
endmodule

bind dram_addr_mux dram_addr_mux_chk chk_i (.*);

// File: tb/dram_addr_mux_tb_top.sv
module dram_addr_mux_tb_top;
  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [2:0]  len;
    logic        wide;
    logic [3:0]  trcd;
    logic [3:0]  tcas;
    logic [3:0]  trp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 2'd2, 3'd0, 1'b1, 4'd1, 4'd1, 4'd1},
    '{32'h1234_5678, 2'd2, 3'd0, 1'b1, 4'd2, 4'd3, 4'd2},
    '{32'h0ABC_DEF4, 2'd1, 3'd0, 1'b0, 4'd3, 4'd2, 4'd1},
    '{32'h1FFF_FFFE, 2'd1, 3'd0, 1'b1, 4'd1, 4'd2, 4'd3},
    '{32'h0000_0101, 2'd0, 3'd0, 1'b0, 4'd2, 4'd1, 4'd2},
    '{32'h0000_0013, 2'd0, 3'd0, 1'b1, 4'd1, 4'd1, 4'd1},
    '{32'h0000_01FC, 2'd1, 3'd3, 1'b0, 4'd2, 4'd2, 4'd2},
    '{32'h1000_03F8, 2'd2, 3'd3, 1'b1, 4'd1, 4'd2, 4'd3},
    '{32'h0555_5500, 2'd2, 3'd7, 1'b1, 4'd2, 4'd1, 4'd1},
    '{32'h0FFF_FFFC, 2'd2, 3'd2, 1'b1, 4'd1, 4'd1, 4'd2}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wide_i = 1'b0;
  logic [3:0]  cfg_trcd_i = 4'd1, cfg_tcas_i = 4'd1, cfg_trp_i = 4'd1;
  logic        req_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [2:0]  req_len_i = '0;
  logic        ack_o;
  logic [1:0]  ras_n_o;
  logic [3:0]  cas_n_o;
  logic [12:0] dram_a_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  dram_addr_mux dut_i (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [12:0] ref_col(input logic [31:0] a, input logic w);
    logic [31:0] s;
    s = w ? (a >> 1) : a;
    return {s[26], s[24], s[22], s[20], s[18], s[8:1]};
  endfunction

  function automatic logic [12:0] ref_row(input logic [31:0] a, input logic w);
    logic [31:0] s;
    s = w ? (a >> 1) : a;
    return {s[25], s[23], s[21], s[19], s[17:9]};
  endfunction

  function automatic logic [3:0] ref_lanes(input logic [31:0] a, input logic [1:0] sz,
                                           input logic w);
    if (!w) return (sz == 2'd0) ? (a[0] ? 4'b0010 : 4'b0001) : 4'b0011;
    case (sz)
      2'd0:    return 4'b0001 << a[1:0];
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic run_req(input vec_t v);
    int bw, sh, beat, rows, exp_rows, hi_run, rcd_run, cas_run;
    logic prev_ras, prev_cas, first, got_ack;
    logic [12:0] prev_a;
    logic [31:0] ba;
    bw = v.wide ? 4 : 2;
    sh = v.wide ? 10 : 9;
    exp_rows = 1;
    for (int k = 1; k <= int'(v.len); k++)
      if (((v.addr + 32'(k*bw)) >> sh) != ((v.addr + 32'((k-1)*bw)) >> sh)) exp_rows++;
    cfg_wide_i = v.wide; cfg_trcd_i = v.trcd; cfg_tcas_i = v.tcas; cfg_trp_i = v.trp;
    req_addr_i = v.addr; req_size_i = v.size; req_len_i = v.len; req_i = 1'b1;
    beat = 0; rows = 0; hi_run = 0; rcd_run = 0; cas_run = 0;
    prev_ras = 1'b0; prev_cas = 1'b0; first = 1'b0; got_ack = 1'b0; prev_a = dram_a_o;
    for (int t = 0; t < 600 && !got_ack; t++) begin
      logic rl, cl;
      @(negedge clk_i);
      rl = (ras_n_o != 2'b11);
      cl = (cas_n_o != 4'hF);
      ba = v.addr + 32'(beat*bw);
      if (rl && !prev_ras) begin
        rows++;
        chk(dram_a_o == ref_row(ba, v.wide), "R2 row map", 32'(dram_a_o), 32'(ref_row(ba, v.wide)));
        chk(prev_a == dram_a_o, "R7 row setup", 32'(prev_a), 32'(dram_a_o));
        chk(ras_n_o == (ba[28] ? 2'b01 : 2'b10), "R3 bank strobe", 32'(ras_n_o),
            32'(ba[28] ? 2'b01 : 2'b10));
        if (rows > 1) chk(hi_run == int'(v.trp) + 1, "R8 precharge", 32'(hi_run), 32'(v.trp + 1));
        rcd_run = 0; first = 1'b1;
      end
      if (cl && !prev_cas) begin
        chk(dram_a_o == ref_col(ba, v.wide), "R1 column map", 32'(dram_a_o),
            32'(ref_col(ba, v.wide)));
        chk(cas_n_o == ~ref_lanes(ba, v.size, v.wide), v.wide ? "R5 lanes" : "R6 lanes",
            32'(cas_n_o), 32'(~ref_lanes(ba, v.size, v.wide)));
        if (first) chk(rcd_run == int'(v.trcd), "R7 rcd", 32'(rcd_run), 32'(v.trcd));
        first = 1'b0; cas_run = 0;
      end
      if (cl) cas_run++;
      if (!cl && prev_cas) begin
        chk(cas_run == int'(v.tcas), "R7 cas width", 32'(cas_run), 32'(v.tcas));
        beat++;
      end
      if (rl && !cl && first) rcd_run++;
      hi_run = rl ? 0 : hi_run + 1;
      if (ack_o) begin
        got_ack = 1'b1;
        req_i = 1'b0;
        chk(hi_run == int'(v.trp) + 1, "R8 final precharge", 32'(hi_run), 32'(v.trp + 1));
        chk(beat == int'(v.len) + 1, "R9 beat count", 32'(beat), 32'(v.len + 1));
        // R10 page crossings reopen rows
        chk(rows == exp_rows, "R10 row opens", 32'(rows), 32'(exp_rows));
      end
      prev_ras = rl; prev_cas = cl; prev_a = dram_a_o;
    end
    chk(got_ack, "R11 ack seen", 32'(got_ack), 32'd1);
    req_i = 1'b0;
    @(negedge clk_i);
    chk(!ack_o, "R11 ack single pulse", 32'(ack_o), 32'd0);
  endtask

  initial begin
    vec_t rv;
    logic bad;
    repeat (3) @(negedge clk_i);
    chk(ras_n_o == 2'b11 && cas_n_o == 4'hF && !ack_o, "R12 reset idle",
        {26'd0, ras_n_o, cas_n_o}, 32'h3F);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) run_req(VECS[i]);
    for (int i = 0; i < 24; i++) begin
      rv.addr = $urandom & 32'h1FFF_FFFF;
      rv.size = 2'($urandom % 3);
      rv.len  = 3'($urandom % 3);
      rv.wide = 1'(i % 2);
      rv.trcd = 4'd1 + 4'($urandom % 3);
      rv.tcas = 4'd1 + 4'($urandom % 3);
      rv.trp  = 4'd1 + 4'($urandom % 3);
      run_req(rv);
    end
    // R4 out-of-range request is ignored
    req_addr_i = 32'h4000_0000; req_size_i = 2'd2; req_len_i = 3'd0; req_i = 1'b1;
    bad = 1'b0;
    repeat (20) begin
      @(negedge clk_i);
      if (ack_o || ras_n_o != 2'b11) bad = 1'b1;
    end
    chk(!bad, "R4 out of range", 32'(bad), 32'd0);
    req_i = 1'b0;
    @(negedge clk_i);
    run_req('{32'h1000_0000, 2'd0, 3'd0, 1'b0, 4'd1, 4'd1, 4'd1});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule